// File: doc/BRIEF.md
# Timer with Four Input Captures

A 16-bit up-counting timebase shared by four input-capture channels. The count advances on a tick taken either from the system clock divided by four or from a synchronized external clock pin, and only while the run bit is set. Each channel watches its own pin and, on its configured event, copies the current count into its own 16-bit register and raises its own event flag.

The first channel's register has two roles. With the capture-mode bit clear it is the period register: the count returns to zero after matching it, and channel 1 does not capture. With the capture-mode bit set the count runs the full 16-bit range, and that register captures like the other three. A small word-wide register port sets up the block and clears flags. Each flag, ANDed with its mask bit, drives one shared interrupt line.

Top module: `cap_timer4`

## Requirements
- R1: After reset, every readable register is zero and irq_o is low.
- R2: CTRL bit 1 selects the tick source. With 0, the count advances once every 4 clk_i cycles. With 1, it advances once per rising edge of ext_clk_i, seen after a two-flop synchronizer.
- R3: While the run bit (CTRL bit 0) is 0 the count holds. A write to address 1 loads the count directly.
- R4: With the capture-mode bit (CTRL bit 2) set, a tick at 0xFFFF wraps the count to 0 and sets the timer flag (FLAGS bit 0). The flag stays set until a write to address 2 with bit 0 set.
- R5: With CTRL bit 2 clear, a tick while the count equals the address-4 register loads 0 and sets the timer flag, and channel 1 never captures.
- R6: A qualified event on channel k (k = 1..4, pin cap_i[k-1]) stores the count as it was before the clock edge into the register at address 3+k and sets FLAGS bit k.
- R7: Channel k's select field is CTRL bits [3+2k:2+2k]. 00 = every falling edge, 01 = every rising edge, 10 = every 4th rising edge, 11 = every 16th rising edge. Pins pass through two synchronizer flops before edge detection.
- R8: Any write to CTRL resets every channel's rising-edge prescale counter.
- R9: An event on a channel whose flag is already set keeps the stored value and sets overflow bit FLAGS[4+k]. Writing 1 to FLAGS bit k clears both the flag and its overflow bit.
- R10: irq_o is the OR over FLAGS[4:0] ANDed with the MASK register (address 3) bits [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address: 0 CTRL, 1 count, 2 FLAGS, 3 MASK, 4..7 channel 1..4 |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| ext_clk_i | input | 1 | External tick source |
| cap_i | input | 4 | Capture pins, bit k-1 for channel k |
| irq_o | output | 1 | Masked OR of all flags |

## Verification
On every cycle the assertions check the following:
- the wrap and period reload, including the timer flag they raise;
- that the count holds while stopped;
- that channel 1 stays frozen in period mode;
- that a flagged channel keeps its value and raises overflow instead;
- that overflow never stands without its flag.

Only the bench's scenarios, compared against the cycle model, can show the event timing:
- the divide-by-four and external tick rates;
- each edge-select encoding;
- the prescale restart on a CTRL write;
- the exact count values latched through the synchronizer delay.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
  typedef enum logic [1:0] {
    SEL_FALL   = 2'b00,
    SEL_RISE   = 2'b01,
    SEL_RISE4  = 2'b10,
    SEL_RISE16 = 2'b11
  } edge_sel_e;

  localparam int PS_W       = 4;
  localparam int PS4_LAST   = 3;
  localparam int PS16_LAST  = 15;

  localparam int A_CTRL  = 0;
  localparam int A_COUNT = 1;
  localparam int A_FLAGS = 2;
  localparam int A_MASK  = 3;
  localparam int A_CAP   = 4;

  localparam int CB_RUN  = 0;
  localparam int CB_CSEL = 1;
  localparam int CB_FOUR = 2;
  localparam int CB_SEL  = 4;
endpackage

// File: rtl/ctimer_tick.sv
module ctimer_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic csel_i,
  input  logic ext_clk_i,
  output logic tick_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;
  logic [2:0]    ext_q;   // [0],[1] sync, [2] previous

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ext_q <= '0;
    end else begin
      div_q <= (div_q == DW'(DIV-1)) ? '0 : div_q + 1'b1;
      ext_q <= {ext_q[1:0], ext_clk_i};
    end
  end

  assign tick_o = run_i & (csel_i ? (ext_q[1] & ~ext_q[2]) : (div_q == DW'(DIV-1)));
endmodule

// File: rtl/ctimer_capch.sv
module ctimer_capch import ctimer_pkg::*; #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pin_i,
  input  logic [1:0]    sel_i,
  input  logic          en_i,
  input  logic          pc_clr_i,
  input  logic          flag_clr_i,
  input  logic [TW-1:0] cnt_i,
  input  logic          wr_i,
  input  logic [TW-1:0] wdata_i,
  output logic [TW-1:0] cap_o,
  output logic          flag_o,
  output logic          ovf_o,
  output logic          evt_o
);
  edge_sel_e       sel;
  logic [2:0]      pin_q;
  logic            rise, fall, evt_raw, flag_live;
  logic [PS_W-1:0] pc_q, pc_last;

  assign sel     = edge_sel_e'(sel_i);
  assign rise    = pin_q[1] & ~pin_q[2];
  assign fall    = ~pin_q[1] & pin_q[2];
  assign pc_last = (sel == SEL_RISE4) ? PS_W'(PS4_LAST) : PS_W'(PS16_LAST);

  always_comb begin
    unique case (sel)
      SEL_FALL:   evt_raw = fall;
      SEL_RISE:   evt_raw = rise;
      SEL_RISE4,
      SEL_RISE16: evt_raw = rise & (pc_q == pc_last);
      default:    evt_raw = 1'b0;
    endcase
  end

  assign evt_o     = evt_raw & en_i;
  assign flag_live = flag_o & ~flag_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= '0;
      pc_q   <= '0;
      cap_o  <= '0;
      flag_o <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      pin_q <= {pin_q[1:0], pin_i};
      if (pc_clr_i)
        pc_q <= '0;
      else if (rise && sel_i[1])
        pc_q <= (pc_q == pc_last) ? '0 : pc_q + 1'b1;

      if (evt_o && !flag_live) begin
        cap_o  <= cnt_i;
        flag_o <= 1'b1;
        ovf_o  <= 1'b0;
      end else begin
        if (wr_i) cap_o <= wdata_i;
        if (evt_o) begin
          ovf_o <= 1'b1;
        end else if (flag_clr_i) begin
          flag_o <= 1'b0;
          ovf_o  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cap_timer4.sv
module cap_timer4 import ctimer_pkg::*; #(
  parameter int TW  = 16,
  parameter int NCH = 4,
  parameter int DIV = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [2:0]     addr_i,
  input  logic [TW-1:0]  wdata_i,
  output logic [TW-1:0]  rdata_o,
  input  logic           ext_clk_i,
  input  logic [NCH-1:0] cap_i,
  output logic           irq_o
);
  localparam int CW = CB_SEL + 2*NCH;
  localparam int FW = 1 + 2*NCH;

  logic [CW-1:0]          ctrl_q;
  logic [NCH:0]           mask_q;
  logic [TW-1:0]          cnt_q;
  logic                   tflag_q;
  logic                   tick, wrap_hit, four_cap;
  logic                   ctrl_wr, cnt_wr, flag_wr, per_wr, mask_wr;
  logic [NCH-1:0]         cflag, ovf, evt, fclr;
  logic [NCH-1:0][TW-1:0] cap_val;

  assign four_cap = ctrl_q[CB_FOUR];
  assign ctrl_wr  = we_i && (addr_i == 3'(A_CTRL));
  assign cnt_wr   = we_i && (addr_i == 3'(A_COUNT));
  assign flag_wr  = we_i && (addr_i == 3'(A_FLAGS));
  assign mask_wr  = we_i && (addr_i == 3'(A_MASK));
  assign per_wr   = we_i && (addr_i == 3'(A_CAP));
  assign wrap_hit = four_cap ? (cnt_q == '1) : (cnt_q == cap_val[0]);

  ctimer_tick #(.DIV(DIV)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ctrl_q[CB_RUN]),
    .csel_i    (ctrl_q[CB_CSEL]),
    .ext_clk_i (ext_clk_i),
    .tick_o    (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
      tflag_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata_i[CW-1:0];
      if (mask_wr) mask_q <= wdata_i[NCH:0];
      if (cnt_wr)
        cnt_q <= wdata_i;
      else if (tick)
        cnt_q <= wrap_hit ? '0 : cnt_q + 1'b1;
      if (tick && wrap_hit && !cnt_wr)
        tflag_q <= 1'b1;
      else if (flag_wr && wdata_i[0])
        tflag_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign fclr[k] = flag_wr & wdata_i[1+k];
    ctimer_capch #(.TW(TW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (cap_i[k]),
      .sel_i      (ctrl_q[CB_SEL+2*k +: 2]),
      .en_i       ((k == 0) ? four_cap : 1'b1),
      .pc_clr_i   (ctrl_wr),
      .flag_clr_i (fclr[k]),
      .cnt_i      (cnt_q),
      .wr_i       ((k == 0) ? per_wr : 1'b0),
      .wdata_i    (wdata_i),
      .cap_o      (cap_val[k]),
      .flag_o     (cflag[k]),
      .ovf_o      (ovf[k]),
      .evt_o      (evt[k])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i >= 3'(A_CAP))
      rdata_o = cap_val[addr_i - 3'(A_CAP)];
    else begin
      unique case (addr_i)
        3'(A_CTRL):  rdata_o = TW'(ctrl_q);
        3'(A_COUNT): rdata_o = cnt_q;
        3'(A_FLAGS): rdata_o = TW'({ovf, cflag, tflag_q});
        3'(A_MASK):  rdata_o = TW'(mask_q);
        default:     rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |({cflag, tflag_q} & mask_q);

  logic unused_ok;
  assign unused_ok = ^{FW};
endmodule

// File: rtl/ctimer_chk.sv
module ctimer_chk #(
  parameter int TW  = 16,
  parameter int NCH = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   tick,
  input logic                   four_cap,
  input logic                   run,
  input logic                   cnt_wr,
  input logic                   per_wr,
  input logic [TW-1:0]          cnt_q,
  input logic                   tflag_q,
  input logic [NCH-1:0]         cflag,
  input logic [NCH-1:0]         ovf,
  input logic [NCH-1:0]         evt,
  input logic [NCH-1:0]         fclr,
  input logic [NCH-1:0][TW-1:0] cap_val
);
  p_wrap_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (four_cap && tick && cnt_q == '1 && !cnt_wr) |=> (cnt_q == '0 && tflag_q));

  p_period_reset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!four_cap && tick && cnt_q == cap_val[0] && !cnt_wr) |=> (cnt_q == '0 && tflag_q));

  p_ch1_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!four_cap && !per_wr) |=> $stable(cap_val[0]));

  p_hold_when_stopped_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_wr) |=> $stable(cnt_q));

  for (genvar k = 0; k < NCH; k++) begin : g_a
    p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt[k] && cflag[k] && !fclr[k] && !(k == 0 && per_wr))
        |=> (ovf[k] && cflag[k] && $stable(cap_val[k])));

    p_ovf_needs_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf[k] |-> cflag[k]);
  end
endmodule

bind cap_timer4 ctimer_chk #(.TW(TW), .NCH(NCH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick     (tick),
  .four_cap (four_cap),
  .run      (ctrl_q[0]),
  .cnt_wr   (cnt_wr),
  .per_wr   (per_wr),
  .cnt_q    (cnt_q),
  .tflag_q  (tflag_q),
  .cflag    (cflag),
  .ovf      (ovf),
  .evt      (evt),
  .fclr     (fclr),
  .cap_val  (cap_val)
);

// File: tb/cap_timer4_test.sv
module cap_timer4_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        ext_clk_i = 1'b0;
  logic [3:0]  cap_i = '0;
  logic        irq_o;

  int total = 0, bad = 0;
  bit done = 0;
  bit auto_pins = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  cap_timer4 uut (.*);

  // behavioural reference model
  int m_div, m_e1, m_e2, m_e3, m_cnt, m_tf, m_ctrl, m_mask;
  int m_s1[4], m_s2[4], m_s3[4], m_pc[4], m_cf[4], m_ov[4], m_cv[4];

  function automatic int m_read(int a);
    int f;
    if (a >= 4) return m_cv[a-4];
    case (a)
      0: return m_ctrl;
      1: return m_cnt;
      2: begin
        f = m_tf;
        for (int k = 0; k < 4; k++) f |= (m_cf[k] << (1+k)) | (m_ov[k] << (5+k));
        return f;
      end
      default: return m_mask;
    endcase
  endfunction

  function automatic int m_irq();
    int f;
    f = m_read(2) & 'h1f & m_mask;
    return (f != 0) ? 1 : 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_div = 0; m_e1 = 0; m_e2 = 0; m_e3 = 0; m_cnt = 0; m_tf = 0; m_ctrl = 0; m_mask = 0;
      for (int k = 0; k < 4; k++) begin
        m_s1[k] = 0; m_s2[k] = 0; m_s3[k] = 0; m_pc[k] = 0; m_cf[k] = 0; m_ov[k] = 0; m_cv[k] = 0;
      end
    end else begin
      int tk, hit, twr, four, w, a;
      w = int'(wdata_i); a = int'(addr_i);
      four = (m_ctrl >> 2) & 1;
      tk = ((m_ctrl & 1) != 0) && (((m_ctrl >> 1) & 1) != 0 ? (m_e2 == 1 && m_e3 == 0) : (m_div == 3));
      hit = four ? (m_cnt == 65535) : (m_cnt == m_cv[0]);
      twr = we_i && a == 1;
      for (int k = 0; k < 4; k++) begin
        int r, f, sel, ev, clr, lim;
        r = (m_s2[k] == 1 && m_s3[k] == 0);
        f = (m_s2[k] == 0 && m_s3[k] == 1);
        sel = (m_ctrl >> (4 + 2*k)) & 3;
        lim = (sel == 2) ? 3 : 15;
        ev = (sel == 0) ? f : (sel == 1) ? r : (r && m_pc[k] == lim);
        if (k == 0 && !four) ev = 0;
        clr = we_i && a == 2 && ((w >> (1+k)) & 1);
        if (ev && !(m_cf[k] && !clr)) begin
          m_cv[k] = m_cnt; m_cf[k] = 1; m_ov[k] = 0;
        end else begin
          if (k == 0 && we_i && a == 4) m_cv[0] = w;
          if (ev) m_ov[k] = 1;
          else if (clr) begin m_cf[k] = 0; m_ov[k] = 0; end
        end
        if (we_i && a == 0) m_pc[k] = 0;
        else if (r && sel >= 2) m_pc[k] = (m_pc[k] == lim) ? 0 : m_pc[k] + 1;
        m_s3[k] = m_s2[k]; m_s2[k] = m_s1[k]; m_s1[k] = cap_i[k];
      end
      if (tk && hit && !twr) m_tf = 1;
      else if (we_i && a == 2 && (w & 1)) m_tf = 0;
      if (twr) m_cnt = w;
      else if (tk) m_cnt = hit ? 0 : (m_cnt + 1) & 'hffff;
      m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_clk_i;
      m_div = (m_div + 1) % 4;
      if (we_i && a == 0) m_ctrl = w & 'hfff;
      if (we_i && a == 3) m_mask = w & 'h1f;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(posedge clk_i) begin
    #5;
    if (rst_ni && !done) begin
      case (int'(addr_i))
        0, 3:    chk("R1 ctrl/mask register", int'(rdata_o), m_read(int'(addr_i)));
        1:       chk("R2 count", int'(rdata_o), m_read(1));
        2:       chk("R9 flags", int'(rdata_o), m_read(2));
        default: chk("R6 capture register", int'(rdata_o), m_read(int'(addr_i)));
      endcase
      chk("R10 irq", int'(irq_o), m_irq());
    end
  end

  int cyc = 0;
  always @(negedge clk_i) begin
    cyc++;
    if (auto_pins) begin
      if (cyc % 7 == 0)  cap_i[0] <= ~cap_i[0];
      if (cyc % 11 == 0) cap_i[1] <= ~cap_i[1];
      if (cyc % 3 == 0)  cap_i[2] <= ~cap_i[2];
      if (cyc % 5 == 0)  cap_i[3] <= ~cap_i[3];
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 3'(a); wdata_i = 16'(d);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      we_i = 1'b0; addr_i = 3'(i % 8);
    end
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = 3'(a);
    #2 v = int'(rdata_o);
  endtask

  task automatic pulse(input int k);
    @(negedge clk_i); cap_i[k] = 1'b1;
    repeat (3) @(negedge clk_i);
    cap_i[k] = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    int v, v2;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk("R1 reset value", v, 0);
    end
    chk("R1 irq after reset", int'(irq_o), 0);

    // R6/R7/R9 free-running four-capture mode, mixed select codes
    wr(3, 'h1f);
    wr(0, 'hE15);
    auto_pins = 1;
    for (int i = 0; i < 40; i++) begin
      idle(60);
      if (i % 3 != 2) wr(2, 'h1f);
    end
    auto_pins = 0;
    cap_i = '0;
    idle(10);

    // R2: divide-by-four tick rate
    wr(1, 0);
    rd(1, v); idle(39); rd(1, v2);
    chk("R2 div4 count over 40 cycles", v2 - v, 10);

    // R3: stop and direct load
    wr(0, 'h004);
    wr(1, 'h1234);
    rd(1, v); idle(40); rd(1, v2);
    chk("R3 count holds when stopped", v2, 'h1234);
    chk("R3 direct load", v, 'h1234);

    // R2: external tick source
    wr(0, 'h007);
    wr(1, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i); ext_clk_i = 1'b1;
      repeat (4) @(negedge clk_i);
      ext_clk_i = 1'b0;
      repeat (4) @(negedge clk_i);
    end
    rd(1, v);
    chk("R2 external tick count", v, 6);

    // R4: 16-bit wrap and sticky flag
    wr(0, 'h005);
    wr(2, 'h1ff);
    wr(1, 'hfffc);
    idle(30);
    rd(2, v);
    chk("R4 wrap flag set", v & 1, 1);
    idle(20);
    rd(2, v);
    chk("R4 wrap flag sticky", v & 1, 1);
    wr(2, 1);
    rd(2, v);
    chk("R4 wrap flag cleared", v & 1, 0);

    // R10: mask gating
    wr(1, 'hfffc); idle(30);
    wr(3, 0);
    rd(0, v);
    chk("R10 irq masked off", int'(irq_o), 0);
    wr(3, 1);
    rd(0, v);
    chk("R10 irq unmasked", int'(irq_o), 1);

    // R9: overflow on channel 2 (falling edges)
    wr(0, 'h005);
    wr(2, 'h1ff);
    pulse(1);
    rd(5, v);
    chk("R6 channel 2 captured", v, m_cv[1]);
    pulse(1);
    rd(5, v2);
    chk("R9 value kept on overflow", v2, v);
    rd(2, v);
    chk("R9 flag and overflow set", v & 'h44, 'h44);
    wr(2, 'h04);
    rd(2, v);
    chk("R9 clear drops overflow", v & 'h44, 0);

    // R8: prescale restart on CTRL write, channel 4 every 16th rising edge
    wr(0, 'hC05);
    wr(2, 'h1ff);
    for (int i = 0; i < 10; i++) pulse(3);
    wr(0, 'hC05);
    for (int i = 0; i < 15; i++) pulse(3);
    rd(2, v);
    chk("R8 no capture before 16th edge after restart", (v >> 4) & 1, 0);
    pulse(3);
    rd(2, v);
    chk("R8 capture on 16th edge after restart", (v >> 4) & 1, 1);
    chk("R7 every-16th capture flag", (v >> 4) & 1, 1);

    // R5: period mode, channel 1 disabled
    wr(0, 'h011);
    wr(4, 7);
    wr(1, 0);
    wr(2, 'h1ff);
    for (int i = 0; i < 6; i++) pulse(0);
    idle(40);
    rd(4, v);
    chk("R5 period register untouched by pin", v, 7);
    rd(2, v);
    chk("R5 channel 1 flag stays clear", (v >> 1) & 1, 0);
    chk("R5 period reload sets timer flag", v & 1, 1);
    rd(1, v);
    chk("R5 count within period", (v <= 7) ? 1 : 0, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule